// File: doc/BRIEF.md
# Filtered Quadrature Decoder with Selectable Resolution

This block turns the two phase-shifted channels of an incremental encoder into count strobes for a position counter. Both channels arrive asynchronously. Each channel passes through a synchroniser and then a level-qualification filter. A new level is taken as real only after it has been seen unchanged on three successive rising clock edges, so short glitches are discarded.

The two filtered channels form a two-bit state. A decoder compares this state with the state it held one clock earlier and classifies the step as forward, backward, or illegal. A two-bit resolution select chooses whether every step is counted (4x), only steps where channel A moves (2x), or a single step per full cycle (1x). The block emits a one-cycle count strobe together with a direction bit. A step in which both channels flip in the same clock produces no count and raises a one-cycle fault strobe instead.

The counter that consumes the strobes is not part of this block, and neither are any bus access or index handling.

Top module: `quad_decoder`

## Requirements
- R1: While `rstN` is low, `countEn`, `upDn` and `illegalErr` are 0 and the filtered state is forced to {A,B}=00. After reset, a first move of the inputs to {A,B}=01 in 4x mode counts up.
- R2: A change on either input that does not survive three consecutive rising-edge samples after synchronisation (for example, a one- or two-cycle pulse) produces no count strobe and no fault strobe.
- R3: With the default parameters, an input change made between clock edges raises `countEn` on the 7th rising edge after the change, and not earlier.
- R4: When `modeSel` is 2'b10 (4x) or 2'b11 (also 4x), every single-channel step produces one count strobe. The state is written {A,B}. The sequence 00→01→11→10→00 counts up (`upDn`=1), and the reverse sequence counts down (`upDn`=0).
- R5: When `modeSel` is 2'b01 (2x), a count strobe is produced only for steps in which channel A changes, with the direction defined as in R4. Steps in which only B changes produce no strobe.
- R6: When `modeSel` is 2'b00 (1x), the only counting steps are 10→00 (up) and 00→10 (down). All other single-channel steps produce no strobe.
- R7: A step in which both filtered channels change in the same clock produces no count strobe and raises `illegalErr` for exactly one cycle.
- R8: `countEn` is a single-cycle pulse per counted step, with `upDn` valid in the same cycle. `upDn` holds its last value when no count is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low reset |
| chA | input | 1 | Encoder channel A, asynchronous |
| chB | input | 1 | Encoder channel B, asynchronous |
| modeSel | input | 2 | Resolution: 00 = 1x, 01 = 2x, 10 or 11 = 4x |
| countEn | output | 1 | One-cycle count strobe |
| upDn | output | 1 | Direction of the strobe: 1 = up, 0 = down |
| illegalErr | output | 1 | One-cycle strobe marking a step where both channels changed together |

## Verification
The bench builds the decoder with its default depths: two synchroniser stages and a three-sample filter. With these depths the end-to-end delay is exactly seven edges, so the latency bound can be checked at a single cycle, and a two-cycle pulse falls just short of qualification. With these values, full forward and reverse cycles can be walked in every resolution mode, including the alias code 11. The same depths also allow the simultaneous-change fault to be reached from both the 00 and 11 states.

// File: rtl/quad_dec_pkg.sv
package quad_dec_pkg;

  typedef enum logic [1:0] {
    RES_1X     = 2'b00,
    RES_2X     = 2'b01,
    RES_4X     = 2'b10,
    RES_4X_ALT = 2'b11
  } resMode_t;

  // Strobes handed from the decode control to the output datapath.
  typedef struct packed {
    logic countStb;
    logic dirUp;
    logic faultStb;
  } decStrobe_t;

  localparam int NUM_CH = 2;

  // Next state of the forward sequence, state written {A,B}.
  function automatic logic [1:0] fwdNext(input logic [1:0] s);
    case (s)
      2'b00:   fwdNext = 2'b01;
      2'b01:   fwdNext = 2'b11;
      2'b11:   fwdNext = 2'b10;
      default: fwdNext = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/qd_chan_filter.sv
module qd_chan_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic levelOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_LEN-1:0]    tapQ;
  logic                   allHigh;
  logic                   allLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      tapQ  <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      tapQ  <= {tapQ[FILT_LEN-2:0], syncQ[SYNC_STAGES-1]};
    end
  end

  assign allHigh = &tapQ;
  assign allLow  = ~|tapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelOut <= 1'b0;
    end else if (allHigh) begin
      levelOut <= 1'b1;
    end else if (allLow) begin
      levelOut <= 1'b0;
    end
  end

  // R2: a qualified level cannot flip again on the very next clock
  filt_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelOut != $past(levelOut)) |=> (levelOut == $past(levelOut)));

endmodule

// File: rtl/qd_control.sv
module qd_control
  import quad_dec_pkg::*;
(
  input  logic [1:0]  curState,
  input  logic [1:0]  prevState,
  input  logic [1:0]  modeSel,
  output decStrobe_t  strobes
);

  logic [1:0] diff;
  logic       oneStep;
  logic       goingUp;
  logic       hit;

  assign diff    = curState ^ prevState;
  assign oneStep = (diff == 2'b01) || (diff == 2'b10);
  assign goingUp = (curState == fwdNext(prevState));

  always_comb begin
    case (resMode_t'(modeSel))
      RES_1X: hit = oneStep &&
                    ((goingUp  && prevState == 2'b10 && curState == 2'b00) ||
                     (!goingUp && prevState == 2'b00 && curState == 2'b10));
      RES_2X: hit = oneStep && diff[1];
      default: hit = oneStep;
    endcase
  end

  always_comb begin
    strobes.countStb = hit;
    strobes.dirUp    = goingUp;
    strobes.faultStb = (diff == 2'b11);
  end

endmodule

// File: rtl/qd_datapath.sv
module qd_datapath
  import quad_dec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  rawIn,
  input  logic [1:0]  modeSel,
  input  decStrobe_t  strobes,
  output logic [1:0]  curState,
  output logic [1:0]  prevState,
  output logic        countEn,
  output logic        upDn,
  output logic        illegalErr
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    qd_chan_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawIn[ch]),
      .levelOut(curState[ch])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevState  <= 2'b00;
      countEn    <= 1'b0;
      upDn       <= 1'b0;
      illegalErr <= 1'b0;
    end else begin
      prevState  <= curState;
      countEn    <= strobes.countStb;
      illegalErr <= strobes.faultStb;
      if (strobes.countStb) upDn <= strobes.dirUp;
    end
  end

  // R7: never count and fault together
  no_err_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(countEn && illegalErr));

  // R4: a count only follows a single-channel step
  one_step_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    countEn |-> ($countones($past(curState ^ prevState)) == 1));

  // R7: a fault only follows a two-channel step
  dual_step_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalErr |-> ($past(curState ^ prevState) == 2'b11));

  // R6: in 1x mode only the 10<->00 steps count
  one_x_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && $past(modeSel) == 2'b00) |->
      (($past(prevState) == 2'b10 && $past(curState) == 2'b00) ||
       ($past(prevState) == 2'b00 && $past(curState) == 2'b10)));

  // R5: in 2x mode only A steps count
  two_x_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && $past(modeSel) == 2'b01) |->
      ($past(curState[1]) != $past(prevState[1])));

endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
  import quad_dec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chA,
  input  logic       chB,
  input  logic [1:0] modeSel,
  output logic       countEn,
  output logic       upDn,
  output logic       illegalErr
);

  decStrobe_t strobes;
  logic [1:0] curState;
  logic [1:0] prevState;

  qd_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rawIn     ({chA, chB}),
    .modeSel   (modeSel),
    .strobes   (strobes),
    .curState  (curState),
    .prevState (prevState),
    .countEn   (countEn),
    .upDn      (upDn),
    .illegalErr(illegalErr)
  );

  qd_control u_ctl (
    .curState (curState),
    .prevState(prevState),
    .modeSel  (modeSel),
    .strobes  (strobes)
  );

endmodule

// File: tb/quad_decoder_bench.sv
module quad_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int STEP_CYC   = 12;
  localparam int LATENCY    = 7;
  localparam int NVEC       = 28;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chA = 1'b0;
  logic       chB = 1'b0;
  logic [1:0] modeSel = 2'b10;
  logic       countEn;
  logic       upDn;
  logic       illegalErr;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_decoder u_quad_decoder (
    .clk       (clk),
    .rstN      (rstN),
    .chA       (chA),
    .chB       (chB),
    .modeSel   (modeSel),
    .countEn   (countEn),
    .upDn      (upDn),
    .illegalErr(illegalErr)
  );

  // {mode[1:0], A, B, expected count, expected up, expected fault}
  localparam logic [6:0] VEC [NVEC] = '{
    // 4x forward then reverse (R1 first row, R4)
    {2'b10, 2'b01, 3'b110}, {2'b10, 2'b11, 3'b110},
    {2'b10, 2'b10, 3'b110}, {2'b10, 2'b00, 3'b110},
    {2'b10, 2'b10, 3'b100}, {2'b10, 2'b11, 3'b100},
    {2'b10, 2'b01, 3'b100}, {2'b10, 2'b00, 3'b100},
    // 2x (R5)
    {2'b01, 2'b01, 3'b000}, {2'b01, 2'b11, 3'b110},
    {2'b01, 2'b10, 3'b000}, {2'b01, 2'b00, 3'b110},
    {2'b01, 2'b10, 3'b100}, {2'b01, 2'b11, 3'b000},
    {2'b01, 2'b01, 3'b100}, {2'b01, 2'b00, 3'b000},
    // 1x (R6)
    {2'b00, 2'b01, 3'b000}, {2'b00, 2'b11, 3'b000},
    {2'b00, 2'b10, 3'b000}, {2'b00, 2'b00, 3'b110},
    {2'b00, 2'b10, 3'b100}, {2'b00, 2'b11, 3'b000},
    {2'b00, 2'b01, 3'b000}, {2'b00, 2'b00, 3'b000},
    // double change (R7)
    {2'b10, 2'b11, 3'b001}, {2'b10, 2'b00, 3'b001},
    // alias 4x code (R4)
    {2'b11, 2'b01, 3'b110}, {2'b11, 2'b00, 3'b100}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a new input state, then watch for a window; outputs sampled at negedge.
  task automatic runStep(input logic [1:0] mode, input logic a, input logic b,
                         input int cycles, output int pulses, output int faults,
                         output int lastUp, output int doubles);
    bit prevCnt = 0;
    pulses = 0; faults = 0; lastUp = -1; doubles = 0;
    @(negedge clk);
    modeSel = mode; chA = a; chB = b;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (countEn) begin
        pulses++;
        lastUp = int'(upDn);
        if (prevCnt) doubles++;
      end
      if (illegalErr) faults++;
      prevCnt = countEn;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p, f, u, d;
    int upBefore;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(countEn == 0 && upDn == 0 && illegalErr == 0, "R1 reset outputs",
          {countEn, upDn, illegalErr}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      runStep(VEC[k][6:5], VEC[k][4], VEC[k][3], STEP_CYC, p, f, u, d);
      check(p == int'(VEC[k][2]), $sformatf("R4/R5/R6 count row %0d", k), p, VEC[k][2]);
      if (VEC[k][2]) check(u == int'(VEC[k][1]), $sformatf("R4 direction row %0d", k), u, VEC[k][1]);
      check(f == int'(VEC[k][0]), $sformatf("R7 fault row %0d", k), f, VEC[k][0]);
      check(d == 0, $sformatf("R8 single pulse row %0d", k), d, 0);
    end

    // R8: upDn holds when nothing counts (last count was down, now B-only step in 2x)
    upBefore = int'(upDn);
    runStep(2'b01, 1'b0, 1'b1, STEP_CYC, p, f, u, d);
    check(p == 0 && int'(upDn) == upBefore, "R8 upDn hold", int'(upDn), upBefore);
    runStep(2'b01, 1'b0, 1'b0, STEP_CYC, p, f, u, d);

    // R2: one- and two-cycle glitches on A from state 00 in 4x
    for (int w = 1; w <= 2; w++) begin
      @(negedge clk);
      modeSel = 2'b10; chA = 1'b1;
      repeat (w) @(negedge clk);
      chA = 1'b0;
      p = 0; f = 0;
      for (int i = 0; i < STEP_CYC; i++) begin
        @(negedge clk);
        if (countEn) p++;
        if (illegalErr) f++;
      end
      check(p == 0 && f == 0, $sformatf("R2 glitch width %0d", w), p + f, 0);
    end

    // R3: exact latency for a change to {A,B}=01
    @(negedge clk);
    modeSel = 2'b10; chB = 1'b1;
    repeat (LATENCY - 1) @(negedge clk);
    check(countEn == 1'b0, "R3 not before edge 7", countEn, 0);
    @(negedge clk);
    check(countEn == 1'b1 && upDn == 1'b1, "R3 strobe at edge 7", countEn, 1);
    @(negedge clk);
    check(countEn == 1'b0, "R8 strobe one cycle", countEn, 0);
    runStep(2'b10, 1'b0, 1'b0, STEP_CYC, p, f, u, d);
    check(p == 1 && u == 0, "R4 return down", p, 1);

    // R1: reset mid-state clears and returns to 00
    runStep(2'b10, 1'b0, 1'b1, STEP_CYC, p, f, u, d);
    @(negedge clk);
    rstN = 1'b0; chB = 1'b0;
    @(negedge clk);
    check(countEn == 0 && upDn == 0 && illegalErr == 0, "R1 reset again",
          {countEn, upDn, illegalErr}, 0);
    rstN = 1'b1;
    runStep(2'b10, 1'b0, 1'b1, STEP_CYC, p, f, u, d);
    check(p == 1 && u == 1, "R1 up after reset", p, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule